// File: doc/BRIEF.md
# Two-Channel I2C Bus Switch Controller

This block is the digital core of a two-way I2C bus switch. It acts as a slave on the upstream bus and holds a small control register that sets which downstream channels are connected. Each downstream channel is represented by one enable output. SCL and SDA are oversampled on the system clock through synchronisers, and SDA is driven through an open-drain pull-down enable.

A master selects channels by writing one byte to the device. The new selection reaches the enable outputs only when the bus shows a STOP condition, so every downstream line is high at the moment it is connected. Two active-low interrupt inputs, one per channel, are merged into one active-low interrupt request, which is also modelled as an open-drain enable. A read returns the stored selection together with the live interrupt state, so the master can find the channel that raised the request.

An asynchronous active-low reset clears the register and returns the protocol engine to idle. The block does not support clock stretching, general call or 10-bit addressing.

Top module: `i2c_chan_switch`

## Requirements
- R1: The device responds to the 7-bit address formed by the prefix 11100 followed by addr_i[1] and then addr_i[0]. It pulls SDA low in the acknowledge slot of a matching address byte. For any other address it leaves SDA released for the whole transaction and nothing changes.
- R2: In a write transfer (bit 0 of the address byte is 0), every data byte is acknowledged and stored. When several bytes arrive in one transfer, the last one is kept.
- R3: Stored bit 0 enables channel 0 (chan_en_o[0]) and stored bit 1 enables channel 1 (chan_en_o[1]). All four combinations are allowed.
- R4: chan_en_o changes only at a STOP condition. A write followed by a repeated START leaves the outputs unchanged until the STOP.
- R5: In a read transfer (bit 0 of the address byte is 1), each byte holds the stored selection in bits 1:0. Bit 4 is 1 when int_ni[0] is low and bit 5 is 1 when int_ni[1] is low. The interrupt bits are taken when the byte is loaded for sending. The same image is sent for every byte until the master NACKs.
- R6: int_oe_o is 1 (request active) whenever any int_ni bit is low, whatever the channel enables are. It is 0 when all int_ni bits are high.
- R7: While rst_ni is low, the stored selection is cleared, chan_en_o is 0 and SDA is released. After reset, a read returns 0 in the selection bits.
- R8: Write bits 2, 3, 6 and 7 are ignored and always read back as 0. Bits 4 and 5 cannot be written.
- R9: SDA is never pulled low in the cycle after a START or STOP is detected. The SDA drive does not change while the synchronised SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Address pins, bit 1 = upper pin |
| scl_i | input | 1 | Upstream SCL line level |
| sda_i | input | 1 | Upstream SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| int_ni | input | 2 | Active-low interrupt inputs, one per channel |
| int_oe_o | output | 1 | 1 pulls the shared interrupt line low |
| chan_en_o | output | 2 | Downstream channel enables |

## Verification
The bench uses the default parameters: two channels, two-stage synchronisers and the 11100 prefix. With these, all four address-pin settings and all four selection combinations can be covered in a short run, together with every pattern of the two interrupt inputs. The bench drives the bus at eight system clocks per quarter bit, which leaves room for the synchroniser delay. Within that timing it covers repeated START, multi-byte writes and reads, a wrong address and a mid-run reset.

// File: rtl/i2c_sw_pkg.sv
package i2c_sw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } sw_state_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_V = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_V;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sw_bus_cond.sv
module sw_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges while SCL holds high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/sw_slave_fsm.sv
module sw_slave_fsm
  import i2c_sw_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] image_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              sda_oe_o
);
  sw_state_e         state_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              is_addr_q, rw_q, oe_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      is_addr_q <= 1'b0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      sel_q     <= '0;
    end else if (start_i) begin
      state_q   <= ST_RX;
      bit_q     <= '0;
      is_addr_q <= 1'b1;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: if (scl_rise_i) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          bit_q <= bit_q + CNT_W'(1);
          if (bit_q == CNT_W'(BYTE_W-1)) state_q <= ST_RX_END;
        end
        ST_RX_END: if (scl_fall_i) begin
          if (is_addr_q) begin
            if (sh_q[BYTE_W-1:1] == dev_addr_i) begin
              oe_q    <= 1'b1;
              rw_q    <= sh_q[0];
              state_q <= ST_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            sel_q   <= sh_q[SEL_W-1:0];
            oe_q    <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: if (scl_fall_i) begin
          is_addr_q <= 1'b0;
          bit_q     <= '0;
          if (is_addr_q && rw_q) begin
            sh_q    <= image_i;
            oe_q    <= ~image_i[BYTE_W-1];
            state_q <= ST_TX;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_RX;
          end
        end
        ST_TX: if (scl_fall_i) begin
          bit_q <= bit_q + CNT_W'(1);
          sh_q  <= sh_q << 1;
          if (bit_q == CNT_W'(BYTE_W-1)) begin
            oe_q    <= 1'b0;
            state_q <= ST_TX_ACK;
          end else begin
            oe_q <= ~sh_q[BYTE_W-2];
          end
        end
        ST_TX_ACK: if (scl_rise_i) state_q <= sda_i ? ST_IDLE : ST_TX_NEXT;
        ST_TX_NEXT: if (scl_fall_i) begin
          sh_q    <= image_i;
          bit_q   <= '0;
          oe_q    <= ~image_i[BYTE_W-1];
          state_q <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  assign sel_o    = sel_q;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
  import i2c_sw_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PIN_W       = 2,
  parameter int INT_LSB     = 4,
  parameter logic [ADDR_W-PIN_W-1:0] ADDR_PREFIX = 5'b11100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] addr_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [N_CH-1:0]  int_ni,
  output logic             int_oe_o,
  output logic [N_CH-1:0]  chan_en_o
);
  localparam int SW = N_CH + 2;

  logic [SW-1:0]     sync_s;
  logic              scl_s, sda_s;
  logic [N_CH-1:0]   int_s;
  logic              start_w, stop_w, scl_rise_w, scl_fall_w;
  logic [N_CH-1:0]   sel_w;
  logic [BYTE_W-1:0] image_w;
  logic [N_CH-1:0]   chan_en_q;

  sw_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_V('1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({int_ni, scl_i, sda_i}),
    .q_o   (sync_s)
  );
  assign sda_s = sync_s[0];
  assign scl_s = sync_s[1];
  assign int_s = sync_s[SW-1:2];

  sw_bus_cond i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w)
  );

  // read image: select bits low, active-high interrupt flags at INT_LSB
  always_comb begin
    image_w = '0;
    image_w[N_CH-1:0] = sel_w;
  end
  logic [BYTE_W-1:0] int_img;
  for (genvar g = 0; g < BYTE_W; g++) begin : g_img
    if (g >= INT_LSB && g < INT_LSB + N_CH) begin : g_int
      assign int_img[g] = ~int_s[g-INT_LSB];
    end else begin : g_zero
      assign int_img[g] = 1'b0;
    end
  end

  sw_slave_fsm #(.SEL_W(N_CH)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .scl_rise_i(scl_rise_w),
    .scl_fall_i(scl_fall_w),
    .sda_i     (sda_s),
    .dev_addr_i({ADDR_PREFIX, addr_i}),
    .image_i   (image_w | int_img),
    .sel_o     (sel_w),
    .sda_oe_o  (sda_oe_o)
  );

  // selection reaches the channels only at STOP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chan_en_q <= '0;
    else if (stop_w) chan_en_q <= sel_w;
  end

  assign chan_en_o = chan_en_q;
  assign int_oe_o  = ~&int_ni;
endmodule

// File: rtl/i2c_chan_switch_chk.sv
module i2c_chan_switch_chk #(
  parameter int N_CH = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_s,
  input logic            start_w,
  input logic            stop_w,
  input logic            sda_oe_o,
  input logic [N_CH-1:0] int_ni,
  input logic            int_oe_o,
  input logic [N_CH-1:0] chan_en_o
);
  p_int_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ni != '1) |-> int_oe_o);

  p_int_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ni == '1) |-> !int_oe_o);

  p_en_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_w |=> $stable(chan_en_o));

  p_reset_clear_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (chan_en_o == '0 && !sda_oe_o));

  p_release_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w || stop_w) |=> !sda_oe_o);

  p_scl_high_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && !start_w && !stop_w) |=> (!scl_s || $stable(sda_oe_o)));
endmodule

bind i2c_chan_switch i2c_chan_switch_chk #(.N_CH(N_CH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .start_w  (start_w),
  .stop_w   (stop_w),
  .sda_oe_o (sda_oe_o),
  .int_ni   (int_ni),
  .int_oe_o (int_oe_o),
  .chan_en_o(chan_en_o)
);

// File: tb/test_i2c_chan_switch.sv
module test_i2c_chan_switch;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_pins = 2'b00;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, int_oe;
  logic [1:0] int_n = 2'b11;
  logic [1:0] chan_en;
  logic       sda_line;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_chan_switch i_i2c_chan_switch (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .addr_i   (addr_pins),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .int_ni   (int_n),
    .int_oe_o (int_oe),
    .chan_en_o(chan_en)
  );

  typedef struct packed {
    logic [1:0] pins;
    logic [7:0] wr;
    logic [1:0] intn;
    logic [7:0] exp_rd;
    logic [1:0] exp_en;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'd0, 8'h01, 2'b11, 8'h01, 2'b01},
    '{2'd1, 8'hFE, 2'b10, 8'h12, 2'b10},
    '{2'd2, 8'h03, 2'b01, 8'h23, 2'b11},
    '{2'd3, 8'hCC, 2'b00, 8'h30, 2'b00},
    '{2'd0, 8'h02, 2'b11, 8'h02, 2'b10},
    '{2'd2, 8'h00, 2'b10, 8'h10, 2'b00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic smp);
    sda_m = b; wq(); scl_m = 1'b1; wq(); smp = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!give_ack, s);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] adr(input logic [1:0] p, input logic rw);
    return {5'b11100, p, rw};
  endfunction

  task automatic do_write(input logic [1:0] p, input logic [7:0] d, output bit a_ack, output bit d_ack);
    bus_start(); wr_byte(adr(p, 1'b0), a_ack); wr_byte(d, d_ack); bus_stop(); wq();
  endtask

  task automatic do_read(input logic [1:0] p, output bit a_ack, output logic [7:0] d);
    bus_start(); wr_byte(adr(p, 1'b1), a_ack); rd_byte(1'b0, d); bus_stop(); wq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit a, d;
    logic [7:0] r0, r1;

    repeat (5) @(negedge clk);
    chk(chan_en == 2'b00 && !sda_oe, "R7 reset state", chan_en, 0);
    rst_ni = 1'b1;
    wq();
    chk(int_oe == 1'b0, "R6 idle int", int_oe, 0);

    foreach (TBL[i]) begin
      addr_pins = TBL[i].pins;
      int_n     = TBL[i].intn;
      do_write(TBL[i].pins, TBL[i].wr, a, d);
      chk(a && d, "R1 R2 ack on write", {a, d}, 3);
      chk(chan_en == TBL[i].exp_en, "R3 chan_en", chan_en, TBL[i].exp_en);
      do_read(TBL[i].pins, a, r0);
      chk(r0 == TBL[i].exp_rd, "R5 R8 readback", r0, TBL[i].exp_rd);
      chk(int_oe == (TBL[i].intn != 2'b11), "R6 int out", int_oe, TBL[i].intn != 2'b11);
    end

    // R1: wrong address pins -> NACK, no change
    addr_pins = 2'd1; int_n = 2'b11;
    do_write(2'd1, 8'h03, a, d);
    do_write(2'd2, 8'h00, a, d);
    chk(!a, "R1 nack on mismatch", a, 0);
    chk(chan_en == 2'b11, "R1 mismatch no effect", chan_en, 3);
    bus_start(); wr_byte(8'h70, a); bus_stop(); wq();
    chk(!a && chan_en == 2'b11, "R1 wrong prefix", chan_en, 3);

    // R4: deferred until STOP, repeated start does not apply
    bus_start(); wr_byte(adr(2'd1, 1'b0), a); wr_byte(8'h01, d);
    chk(chan_en == 2'b11, "R4 held before stop", chan_en, 3);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    wr_byte(adr(2'd1, 1'b1), a); rd_byte(1'b0, r0);
    chk(chan_en == 2'b11, "R4 held over repeated start", chan_en, 3);
    chk(r0 == 8'h01, "R5 stored select readable", r0, 8'h01);
    bus_stop(); wq();
    chk(chan_en == 2'b01, "R4 applied at stop", chan_en, 1);

    // R2: last of several bytes kept
    bus_start(); wr_byte(adr(2'd1, 1'b0), a);
    wr_byte(8'h01, d); wr_byte(8'h03, d); wr_byte(8'h02, d);
    chk(d, "R2 ack later bytes", d, 1);
    bus_stop(); wq();
    chk(chan_en == 2'b10, "R2 last byte kept", chan_en, 2);

    // R5: multi-byte read returns same image
    int_n = 2'b01;
    bus_start(); wr_byte(adr(2'd1, 1'b1), a); rd_byte(1'b1, r0); rd_byte(1'b0, r1); bus_stop(); wq();
    chk(r0 == 8'h22 && r1 == 8'h22, "R5 repeated image", {r0, r1}, 16'h2222);

    // R6: interrupt with channel disabled
    do_write(2'd1, 8'h00, a, d);
    int_n = 2'b10; wq();
    chk(chan_en == 2'b00 && int_oe, "R6 int with channel off", int_oe, 1);
    int_n = 2'b11; wq();

    // R7: reset mid-run
    do_write(2'd1, 8'h03, a, d);
    rst_ni = 1'b0; repeat (3) @(negedge clk);
    chk(chan_en == 2'b00 && !sda_oe, "R7 reset clears", chan_en, 0);
    rst_ni = 1'b1; wq();
    do_read(2'd1, a, r0);
    chk(a && r0 == 8'h00, "R7 register cleared", r0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule